// File: doc/BRIEF.md
# Chained-Operand Multiplier Slice

This block is a slice of several 18x18 multiplier lanes, four by default, grouped into two equal halves. Each lane registers its A and B operands, multiplies them and registers the full 36-bit product. The operands therefore reach the output two enabled clock edges after they are presented. Operands narrower than 18 bits are widened at the input. Each operand is sign-extended or zero-extended according to its own sign control. Two runtime controls, one for every A operand and one for every B operand, may change on every cycle.

Elaboration parameters choose how each operand register loads. A lane named in the chain mask takes its A operand from the A register of the lane before it. A run of chained lanes then forms a tap delay line with no external logic. The first lane of each half can also have a feedback multiplexer on its B register. When the runtime select for that half is high, the lane takes the upper 18 bits of its own registered product as B. This gives the one-sample recursion needed by recursive filters. Each half has at most one such feedback input.

A shared clock enable gates all registers. A synchronous clear and an active-low asynchronous reset both zero them.

Top module: `mslice_top`

## Requirements
- R1: While `rst_ni` is low, every product on `p_o` reads zero, with no clock edge needed.
- R2: A parallel-loaded operand pair presented before enabled edge k produces its product on `p_o` just after enabled edge k+1. Lane i's product is at `p_o[36*i +: 36]`.
- R3: When `signa_i` and `signb_i` are both 0, the operands are zero-extended from `DATA_W` bits. The product is their unsigned 36-bit product.
- R4: A sign control of 1 sign-extends its operand from bit `DATA_W-1`. If either operand is signed, the product is the 36-bit two's complement product. The other operand keeps its own extension.
- R5: The sign controls are captured together with the operands on each enabled edge. A change from one cycle to the next applies only to the operands captured in that cycle.
- R6: A lane whose bit is set in `CHAIN_MASK` loads, on each enabled edge, the previous lane's A register and the sign captured with it. Its own `a_i` field has no effect.
- R7: When the first lane of half h has bit h set in `LOOP_MASK` and `lb_sel_i[h]` is 1, it loads B from bits 35:18 of its own registered product. That B counts as signed when the product was signed, and its `b_i` field has no effect. When `lb_sel_i[h]` is 0, the lane loads B from `b_i`.
- R8: With `en_i` low and `clr_i` low, no operand or product register changes, whatever the data inputs do.
- R9: `clr_i` high zeroes all operand and product registers at the next edge, whether or not `en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for all registers |
| clr_i | input | 1 | Synchronous clear, overrides enable |
| signa_i | input | 1 | 1: A operands signed, 0: unsigned |
| signb_i | input | 1 | 1: B operands signed, 0: unsigned |
| lb_sel_i | input | N_MULT/2 | Per half: 1 selects product feedback as B of the first lane |
| a_i | input | N_MULT*DATA_W | A operands, lane i at [DATA_W*i +: DATA_W] |
| b_i | input | N_MULT*DATA_W | B operands, lane i at [DATA_W*i +: DATA_W] |
| p_o | output | N_MULT*36 | Registered products, lane i at [36*i +: 36] |

## Verification
The bench builds four lanes with `DATA_W` = 16, so both zero-padding and sign-padding of two bits are in play. It sets `CHAIN_MASK` = 4'b1110, which makes lanes 1 to 3 a three-tap delay line fed from lane 0 that crosses the half boundary. It sets `LOOP_MASK` = 2'b10, which gives lane 2 a feedback B input while lane 0 keeps a fixed parallel B. Under this configuration a single stimulus stream covers parallel, chained and recursive loading at once. Junk on the ignored `a_i` and `b_i` fields shows that those fields have no effect.

// File: rtl/mslice_pkg.sv
package mslice_pkg;
  localparam int NAT_W  = 18;
  localparam int PROD_W = 2 * NAT_W;
  localparam int FB_LSB = PROD_W - NAT_W;

  typedef logic [NAT_W-1:0]  opnd_t;
  typedef logic [PROD_W-1:0] prod_t;
endpackage

// File: rtl/mslice_ext.sv
module mslice_ext
  import mslice_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] d_i,
  input  logic              sgn_i,
  output opnd_t             q_o
);
  localparam int PAD_W = NAT_W - DATA_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign q_o = {{PAD_W{sgn_i & d_i[DATA_W-1]}}, d_i};
    end else begin : g_full
      assign q_o = d_i;
    end
  endgenerate

  initial begin
    a_r4_width_fits: assert (DATA_W <= NAT_W && DATA_W > 0);
  end
endmodule

// File: rtl/mslice_lane.sv
module mslice_lane
  import mslice_pkg::*;
#(
  parameter bit CHAIN_A = 1'b0,
  parameter bit LOOP_B  = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  clr_i,
  input  opnd_t a_par_i,
  input  logic  a_par_sgn_i,
  input  opnd_t a_chain_i,
  input  logic  a_chain_sgn_i,
  input  opnd_t b_par_i,
  input  logic  b_par_sgn_i,
  input  logic  lb_sel_i,
  output opnd_t a_q_o,
  output logic  a_sgn_o,
  output prod_t p_o
);
  opnd_t a_q, b_q, a_d, b_d;
  logic  a_sgn_q, b_sgn_q, p_sgn_q, a_sgn_d, b_sgn_d;
  prod_t p_q;
  logic signed [NAT_W:0]    a_x, b_x;
  logic signed [PROD_W-1:0] prod;
  logic use_fb;

  assign use_fb = LOOP_B && lb_sel_i;

  always_comb begin
    a_d     = CHAIN_A ? a_chain_i     : a_par_i;
    a_sgn_d = CHAIN_A ? a_chain_sgn_i : a_par_sgn_i;
    b_d     = use_fb  ? p_q[PROD_W-1:FB_LSB] : b_par_i;
    b_sgn_d = use_fb  ? p_sgn_q : b_par_sgn_i;
  end

  // one extra bit makes every sign mix a signed multiply
  assign a_x  = {a_sgn_q & a_q[NAT_W-1], a_q};
  assign b_x  = {b_sgn_q & b_q[NAT_W-1], b_q};
  assign prod = PROD_W'(a_x) * PROD_W'(b_x);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; a_sgn_q <= 1'b0; b_sgn_q <= 1'b0;
      p_q <= '0; p_sgn_q <= 1'b0;
    end else if (clr_i) begin
      a_q <= '0; b_q <= '0; a_sgn_q <= 1'b0; b_sgn_q <= 1'b0;
      p_q <= '0; p_sgn_q <= 1'b0;
    end else if (en_i) begin
      a_q     <= a_d;
      b_q     <= b_d;
      a_sgn_q <= a_sgn_d;
      b_sgn_q <= b_sgn_d;
      p_q     <= prod_t'(prod);
      p_sgn_q <= a_sgn_q | b_sgn_q;
    end
  end

  assign a_q_o   = a_q;
  assign a_sgn_o = a_sgn_q;
  assign p_o     = p_q;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(p_q) && $stable(a_q) && $stable(b_q)));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (p_q == '0 && a_q == '0 && b_q == '0));

  generate
    if (CHAIN_A) begin : g_chain_chk
      a_r6_chain_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !clr_i) |=> (a_q == $past(a_chain_i) && a_sgn_q == $past(a_chain_sgn_i)));
    end
    if (LOOP_B) begin : g_loop_chk
      a_r7_loop_feed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !clr_i && lb_sel_i) |=> (b_q == $past(p_q[PROD_W-1:FB_LSB])));
    end
  endgenerate
endmodule

// File: rtl/mslice_top.sv
module mslice_top
  import mslice_pkg::*;
#(
  parameter int                 N_MULT     = 4,
  parameter int                 DATA_W     = 16,
  parameter logic [N_MULT-1:0]  CHAIN_MASK = 4'b1110,
  parameter logic [1:0]         LOOP_MASK  = 2'b10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     clr_i,
  input  logic                     signa_i,
  input  logic                     signb_i,
  input  logic [N_MULT/2-1:0]      lb_sel_i,
  input  logic [N_MULT*DATA_W-1:0] a_i,
  input  logic [N_MULT*DATA_W-1:0] b_i,
  output logic [N_MULT*PROD_W-1:0] p_o
);
  localparam int N_HALF = 2;
  localparam int HALF_W = N_MULT / N_HALF;

  opnd_t a_ext [N_MULT];
  opnd_t b_ext [N_MULT];
  opnd_t chain_q [N_MULT+1];
  logic  chain_sgn [N_MULT+1];

  assign chain_q[0]   = a_ext[0];
  assign chain_sgn[0] = signa_i;

  generate
    for (genvar i = 0; i < N_MULT; i++) begin : g_lane
      localparam int  HALF_IX = i / HALF_W;
      localparam bit  FIRST   = (i % HALF_W) == 0;
      localparam bit  HAS_FB  = FIRST && LOOP_MASK[HALF_IX];
      localparam bit  HAS_CH  = (i > 0) && CHAIN_MASK[i];

      mslice_ext #(.DATA_W(DATA_W)) u_ext_a (
        .d_i(a_i[DATA_W*i +: DATA_W]), .sgn_i(signa_i), .q_o(a_ext[i]));
      mslice_ext #(.DATA_W(DATA_W)) u_ext_b (
        .d_i(b_i[DATA_W*i +: DATA_W]), .sgn_i(signb_i), .q_o(b_ext[i]));

      mslice_lane #(.CHAIN_A(HAS_CH), .LOOP_B(HAS_FB)) u_lane (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .en_i          (en_i),
        .clr_i         (clr_i),
        .a_par_i       (a_ext[i]),
        .a_par_sgn_i   (signa_i),
        .a_chain_i     (chain_q[i]),
        .a_chain_sgn_i (chain_sgn[i]),
        .b_par_i       (b_ext[i]),
        .b_par_sgn_i   (signb_i),
        .lb_sel_i      (lb_sel_i[HALF_IX]),
        .a_q_o         (chain_q[i+1]),
        .a_sgn_o       (chain_sgn[i+1]),
        .p_o           (p_o[PROD_W*i +: PROD_W])
      );
    end
  endgenerate

  a_r9_chain_tail_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (chain_q[N_MULT] == '0 && !chain_sgn[N_MULT]));

  initial begin
    a_r7_half_split: assert (N_MULT % N_HALF == 0 && N_MULT >= N_HALF);
  end
endmodule

// File: tb/mslice_top_test.sv
module mslice_top_test;
  localparam int CLK_P = 10;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, clr_i = 1'b0, signa_i = 1'b0, signb_i = 1'b0;
  logic [1:0] lb_sel_i = '0;
  logic [N*DW-1:0] a_i = '0, b_i = '0;
  logic [N*36-1:0] p_o;

  int n_run = 0, n_fail = 0;

  mslice_top #(.N_MULT(N), .DATA_W(DW), .CHAIN_MASK(4'b1110), .LOOP_MASK(2'b10)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .clr_i(clr_i),
    .signa_i(signa_i), .signb_i(signb_i), .lb_sel_i(lb_sel_i),
    .a_i(a_i), .b_i(b_i), .p_o(p_o));

  always #(CLK_P/2) clk = ~clk;

  // {sa, sb, lb, a0, b0, b1, b2, b3}
  localparam logic [82:0] VEC [NV] = '{
    {3'b000, 16'h0003, 16'h0005, 16'h0007, 16'h0009, 16'h000B},
    {3'b000, 16'hFFFF, 16'hFFFF, 16'h0002, 16'h0003, 16'h0004},
    {3'b100, 16'hFFFD, 16'hFFFF, 16'h0010, 16'h0011, 16'h0012},
    {3'b010, 16'h8000, 16'hFFFE, 16'h1234, 16'h0021, 16'hF00F},
    {3'b110, 16'h8000, 16'h8000, 16'h7FFF, 16'h4000, 16'h8001},
    {3'b111, 16'h0002, 16'h7FFF, 16'hABCD, 16'h5555, 16'h0101},
    {3'b111, 16'hFFF0, 16'h0003, 16'h0F0F, 16'hAAAA, 16'hFFFF},
    {3'b001, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555},
    {3'b100, 16'h7FFF, 16'h7FFF, 16'h8888, 16'h9999, 16'h0001},
    {3'b011, 16'hC000, 16'h0002, 16'h0077, 16'hEEEE, 16'h8000}
  };

  logic [17:0] ma [N], mb [N];
  logic        mas [N], mbs [N], mps [N];
  logic [35:0] mp [N];

  function automatic logic [17:0] ext(input logic [15:0] x, input logic s);
    return {{2{s & x[15]}}, x};
  endfunction

  function automatic logic [35:0] mul(input logic [17:0] a, input logic as,
                                      input logic [17:0] b, input logic bs);
    logic signed [18:0] ax, bx;
    logic signed [35:0] r;
    ax = {as & a[17], a};
    bx = {bs & b[17], b};
    r = 36'(ax) * 36'(bx);
    return r;
  endfunction

  task automatic model_zero();
    for (int i = 0; i < N; i++) begin
      ma[i] = '0; mb[i] = '0; mas[i] = 0; mbs[i] = 0; mps[i] = 0; mp[i] = '0;
    end
  endtask

  task automatic check(input string tag, input int lane, input logic [35:0] act,
                       input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s lane %0d: actual %h expected %h", tag, lane, act, exp);
    end
  endtask

  task automatic check_all(input string t0, input string t1, input string t2,
                           input string t3);
    check(t0, 0, p_o[0 +: 36], mp[0]);
    check(t1, 1, p_o[36 +: 36], mp[1]);
    check(t2, 2, p_o[72 +: 36], mp[2]);
    check(t3, 3, p_o[108 +: 36], mp[3]);
  endtask

  // ignored A fields of chained lanes always carry junk
  task automatic step(input logic en, input logic clr, input logic sa, input logic sb,
                      input logic lb, input logic [15:0] a0, input logic [15:0] b0,
                      input logic [15:0] b1, input logic [15:0] b2, input logic [15:0] b3);
    logic [17:0] na [N], nb [N];
    logic        nas [N], nbs [N], nps [N];
    logic [35:0] np [N];
    @(negedge clk);
    en_i = en; clr_i = clr; signa_i = sa; signb_i = sb; lb_sel_i = {lb, 1'b0};
    a_i = {16'hDEAD ^ a0, 16'hBEEF ^ b0, 16'h5A5A ^ b1, a0};
    b_i = {b3, b2, b1, b0};
    @(posedge clk);
    if (clr) model_zero();
    else if (en) begin
      for (int i = 0; i < N; i++) begin
        np[i]  = mul(ma[i], mas[i], mb[i], mbs[i]);
        nps[i] = mas[i] | mbs[i];
      end
      na[0] = ext(a0, sa); nas[0] = sa;
      for (int i = 1; i < N; i++) begin na[i] = ma[i-1]; nas[i] = mas[i-1]; end
      nb[0] = ext(b0, sb); nbs[0] = sb;
      nb[1] = ext(b1, sb); nbs[1] = sb;
      if (lb) begin nb[2] = mp[2][35:18]; nbs[2] = mps[2]; end
      else    begin nb[2] = ext(b2, sb);  nbs[2] = sb;     end
      nb[3] = ext(b3, sb); nbs[3] = sb;
      for (int i = 0; i < N; i++) begin
        ma[i] = na[i]; mas[i] = nas[i]; mb[i] = nb[i]; mbs[i] = nbs[i];
        mp[i] = np[i]; mps[i] = nps[i];
      end
    end
    #1;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_zero();
    #(CLK_P * 2 + 3);
    // R1: outputs zero during reset
    check_all("R1", "R1", "R1", "R1");
    @(negedge clk); rst_ni = 1'b1;

    // R2..R7: table walk; lane 0 parallel, 1..3 chained, 2 feedback
    for (int v = 0; v < NV; v++) begin
      logic [82:0] e;
      e = VEC[v];
      step(1'b1, 1'b0, e[82], e[81], e[80], e[79:64], e[63:48], e[47:32], e[31:16], e[15:0]);
      check_all((e[82] | e[81]) ? "R4/R5" : "R2/R3", "R6", e[80] ? "R7" : "R6", "R6");
    end

    // R8: enable low with changing inputs holds everything
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h9999, 16'h8888, 16'h7777, 16'h6666, 16'h5555);
    check_all("R8", "R8", "R8", "R8");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h4321, 16'h1111, 16'h2222, 16'h3333);
    check_all("R8", "R8", "R8", "R8");
    // held operands still produce their products afterwards
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001);
    check_all("R8", "R6", "R7", "R6");

    // R7: feedback recursion from a nonzero seed
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF, 16'h0001, 16'h7FFF, 16'h0002);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF, 16'h0001, 16'h7FFF, 16'h0002);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h7FFF, 16'h7FFF, 16'h0001, 16'h7FFF, 16'h0002);
    check_all("R4", "R6", "R7", "R6");
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h7FFF, 16'h0003, 16'h0002, 16'h0000, 16'h0001);
      check_all("R4", "R6", "R7", "R6");
    end

    // R9: clear overrides a low enable
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h4444, 16'h4444, 16'h4444, 16'h4444, 16'h4444);
    check_all("R9", "R9", "R9", "R9");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h4444, 16'h4444, 16'h4444, 16'h4444, 16'h4444);
    check_all("R9", "R9", "R9", "R9");
    // R2: first product after clear arrives after two enabled edges
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0500);
    check_all("R2", "R2", "R2", "R2");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    check_all("R2", "R6", "R2", "R2");

    // R1: asynchronous reset mid-run
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    #2 rst_ni = 1'b0;
    #1 model_zero();
    check_all("R1", "R1", "R1", "R1");
    @(negedge clk); rst_ni = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule